// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Channel

This block is one timer channel built around a single up-counter and a single companion register. A two-bit mode field gives the pair one of four jobs. In reload mode the channel is a periodic timer. In clock-out mode it divides its count source into a square wave on the timer pin. In capture mode it timestamps rising edges arriving on that pin. In compare-output mode it drives a programmed level onto the pin when the counter reaches the register value.

The counter advances on either a prescaled clock enable or rising edges of an external clock pin. The external pin is synchronised first. A small register port lets software read and write the counter, the register and the control word. A one-cycle request pulse marks each counter overflow. The timer pin is bidirectional, and the block drives it except in capture mode.

Top module: `mtimer_chan`

## Requirements
- R1: After reset the counter, the register, the control word and the pin level are all zero, `ovf_req` is low and `pin_oe` is high.
- R2: The control word is five bits: bit 0 run, bits 2:1 mode (0 reload, 1 clock-out, 2 capture, 3 compare-output), bit 3 source (0 `tick_en`, 1 external clock), bit 4 preset level. While run is 1, a count event adds one to the counter. With source 0, a count event is a cycle in which `tick_en` is high. With source 1, a count event is a rising edge of `ext_clk` seen through a two-flop synchroniser plus an edge flop. A level that rises before clock edge k is counted at edge k+2.
- R3: A count event that finds the counter at FFFFh is an overflow. At the same edge that updates the counter, `ovf_req` goes high for exactly one cycle.
- R4: In modes 0 and 1 an overflow loads the counter from the register.
- R5: In mode 1 each overflow inverts the pin level.
- R6: In mode 2 `pin_oe` is low. A rising edge of `pin_in`, seen through two synchroniser flops plus an edge flop, copies the counter value of that cycle into the register.
- R7: In mode 3 with run set, a cycle in which the counter equals the register sets the pin level to the preset bit at the next edge.
- R8: In modes 0, 1 and 3 `pin_oe` is high and `pin_out` carries the pin level.
- R9: A software write to the counter takes priority over counting and cancels the overflow pulse. A software write to the register takes priority over a capture.
- R10: While run is 0 the counter holds its value and `ovf_req` stays low.
- R11: `bus_rdata` shows the counter at address 0, the register at address 1, the control word zero-extended at address 2, and zero at address 3. Writes take effect at the next edge.
- R12: In modes 2 and 3 an overflow wraps the counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| ext_clk | input | 1 | External count clock, asynchronous |
| pin_in | input | 1 | Timer pin input value, asynchronous |
| pin_out | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| ovf_req | output | 1 | One-cycle overflow request |

## Verification
The bench compares the design against a cycle model on every clock while it steps through the modes. It seeds the counter near FFFFh so that overflows happen often. A design that wrapped to zero in reload mode, or reloaded in capture mode, would drift from the model right after the first overflow. External-clock and capture edges are placed so that an off-by-one synchroniser depth moves the count or the captured value by one cycle. One counter write is made on the exact overflow cycle, and a missing write priority shows up there as a stray request pulse. Compare-output is checked with both preset levels, and a channel left stopped must keep both its counter and its request line still.

// File: rtl/mtimer_chan.sv
module mtimer_chan #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          ext_clk,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          ovf_req
);
  localparam int CW = 5;
  localparam logic [1:0] M_RELOAD = 2'd0, M_CLKOUT = 2'd1, M_CAPT = 2'd2, M_CMP = 2'd3;

  logic [W-1:0]  cnt, cmp_reg;
  logic [CW-1:0] ctrl;
  logic [2:0]    ext_s, pin_s;
  logic          pin_q;

  wire       run   = ctrl[0];
  wire [1:0] mode  = ctrl[2:1];
  wire       src   = ctrl[3];
  wire       level = ctrl[4];

  wire wr_cnt  = bus_wr && bus_addr == AW'(0);
  wire wr_reg  = bus_wr && bus_addr == AW'(1);
  wire wr_ctl  = bus_wr && bus_addr == AW'(2);

  wire ext_rise = ext_s[1] & ~ext_s[2];
  wire pin_rise = pin_s[1] & ~pin_s[2];
  wire inc      = run & (src ? ext_rise : tick_en);
  wire wrap     = inc && (cnt == {W{1'b1}}) && !wr_cnt;
  wire cap_hit  = (mode == M_CAPT) && pin_rise;
  wire cmp_hit  = run && (mode == M_CMP) && (cnt == cmp_reg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s <= '0;
      pin_s <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk};
      pin_s <= {pin_s[1:0], pin_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (wr_cnt)   cnt <= bus_wdata;
    else if (wrap)     cnt <= (mode == M_RELOAD || mode == M_CLKOUT) ? cmp_reg : '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_reg <= '0;
    else if (wr_reg)   cmp_reg <= bus_wdata;
    else if (cap_hit)  cmp_reg <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      pin_q   <= 1'b0;
      ovf_req <= 1'b0;
    end else begin
      if (wr_ctl) ctrl <= bus_wdata[CW-1:0];
      ovf_req <= wrap;
      if (mode == M_CLKOUT && wrap) pin_q <= ~pin_q;
      else if (cmp_hit)             pin_q <= level;
    end
  end

  assign pin_out = pin_q;
  assign pin_oe  = (mode != M_CAPT);

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = cnt;
      AW'(1):  bus_rdata = cmp_reg;
      AW'(2):  bus_rdata = W'(ctrl);
      default: bus_rdata = '0;
    endcase
  end
endmodule

module mtimer_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inc,
  input logic         wr_cnt,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp_reg,
  input logic [4:0]   ctrl,
  input logic         pin_q,
  input logic         ovf_req
);
  wire top = (cnt == {W{1'b1}});

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && top && !wr_cnt) |=> ovf_req);
  p_ovf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && top && !wr_cnt) |=> !ovf_req);
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && top && !wr_cnt && ctrl[2:1] == 2'd0) |=> cnt == $past(cmp_reg));
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && top && !wr_cnt && ctrl[2:1] == 2'd1) |=> pin_q != $past(pin_q));
  p_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[2:1] == 2'd3 && cnt == cmp_reg) |=> pin_q == $past(ctrl[4]));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wr_cnt) |=> $stable(cnt));
  p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && top && !wr_cnt && ctrl[2]) |=> cnt == '0);
endmodule

bind mtimer_chan mtimer_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc(inc), .wr_cnt(wr_cnt), .cnt(cnt),
  .cmp_reg(cmp_reg), .ctrl(ctrl), .pin_q(pin_q), .ovf_req(ovf_req)
);

// File: tb/mtimer_chan_bench.sv
`timescale 1ns/1ps
module mtimer_chan_bench;
  logic clk = 0, rst_n = 0;
  logic tick_en = 0, ext_clk = 0, pin_in = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic pin_out, pin_oe, ovf_req;
  logic [15:0] bus_rdata;

  always #2.5 clk = ~clk;

  mtimer_chan u_mtimer_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk(ext_clk),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_req(ovf_req));

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // Behavioural reference state
  int m_cnt, m_reg, m_ctl, m_ovf, m_pin;
  int e_hist[$], p_hist[$];

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_reg = 0; m_ctl = 0; m_ovf = 0; m_pin = 0;
      e_hist = '{0, 0, 0}; p_hist = '{0, 0, 0};
    end else begin
      int mode, nc, nr, np, nctl;
      bit run, erise, prise, tk, inc, wrap, wc, wr, wk;
      run   = m_ctl[0];
      mode  = (m_ctl >> 1) & 3;
      erise = e_hist[1] && !e_hist[2];
      prise = p_hist[1] && !p_hist[2];
      tk    = m_ctl[3] ? erise : tick_en;
      inc   = run && tk;
      wc    = bus_wr && bus_addr == 0;
      wr    = bus_wr && bus_addr == 1;
      wk    = bus_wr && bus_addr == 2;
      wrap  = inc && m_cnt == 65535 && !wc;
      if (wc) nc = bus_wdata;
      else if (wrap) nc = (mode < 2) ? m_reg : 0;
      else if (inc) nc = m_cnt + 1;
      else nc = m_cnt;
      nr = wr ? int'(bus_wdata) : (mode == 2 && prise) ? m_cnt : m_reg;
      if (mode == 1 && wrap) np = 1 - m_pin;
      else if (mode == 3 && run && m_cnt == m_reg) np = m_ctl[4];
      else np = m_pin;
      nctl = wk ? int'(bus_wdata[4:0]) : m_ctl;
      m_cnt = nc; m_reg = nr; m_pin = np; m_ctl = nctl; m_ovf = wrap;
      e_hist.push_front(ext_clk); void'(e_hist.pop_back());
      p_hist.push_front(pin_in);  void'(p_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rd;
      case (bus_addr)
        0: exp_rd = m_cnt;
        1: exp_rd = m_reg;
        2: exp_rd = m_ctl;
        default: exp_rd = 0;
      endcase
      chk(cur_req, "ovf_req", ovf_req, m_ovf);
      chk(cur_req, "pin_out", pin_out, m_pin);
      chk("R8", "pin_oe", pin_oe, ((m_ctl >> 1) & 3) != 2);
      chk(cur_req, "bus_rdata", bus_rdata, exp_rd);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = a[1:0]; bus_wdata = d[15:0];
    step();
    bus_wr = 0;
  endtask

  task automatic run_for(int n, bit rnd_tick);
    for (int i = 0; i < n; i++) begin
      tick_en = rnd_tick ? 1'($urandom_range(0, 1)) : 1'b1;
      bus_addr = 2'(i % 4);
      step();
    end
    bus_addr = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    #0.5;
    cur_req = "R1";
    chk("R1", "count after reset", bus_rdata, 0);
    chk("R1", "ovf after reset", ovf_req, 0);
    chk("R1", "oe after reset", pin_oe, 1);
    chk("R1", "pin after reset", pin_out, 0);
    step();

    cur_req = "R11";
    wr(1, 16'h1234); wr(2, 5'b11010); bus_addr = 1; step(); bus_addr = 2; step();
    bus_addr = 3; step();

    cur_req = "R4";
    wr(2, 5'b00000); wr(1, 16'hFFF8); wr(0, 16'hFFF0);
    wr(2, 5'b00001);
    run_for(60, 1);

    cur_req = "R3";
    run_for(40, 0);

    cur_req = "R5";
    wr(2, 5'b00000); wr(1, 16'hFFFC); wr(0, 16'hFFFA);
    wr(2, 5'b00011);
    run_for(50, 0);

    cur_req = "R2";
    wr(2, 5'b01010); wr(1, 16'hFFFE); wr(0, 16'hFFFB); wr(2, 5'b01011);
    for (int i = 0; i < 60; i++) begin
      ext_clk = (i % 6) < 3;
      tick_en = 1;
      bus_addr = 2'(i % 4);
      step();
    end

    cur_req = "R10";
    wr(2, 5'b00000); wr(0, 16'hFFFF);
    run_for(20, 0);

    cur_req = "R6";
    wr(1, 16'h0000); wr(0, 16'hFFF0); wr(2, 5'b00101);
    for (int i = 0; i < 50; i++) begin
      pin_in = (i % 11) > 6;
      tick_en = 1;
      bus_addr = 2'(i % 2);
      step();
    end

    cur_req = "R12";
    run_for(30, 0);

    cur_req = "R7";
    wr(2, 5'b10110); wr(1, 16'h0020); wr(0, 16'h0010); wr(2, 5'b10111);
    run_for(30, 0);
    wr(2, 5'b00111); wr(0, 16'h0018);
    run_for(20, 0);

    cur_req = "R9";
    wr(2, 5'b00001); wr(1, 16'h4000); wr(0, 16'hFFFE);
    tick_en = 1; step();
    bus_wr = 1; bus_addr = 0; bus_wdata = 16'h0100; step();
    bus_wr = 0; bus_addr = 0; step(2);
    wr(2, 5'b00100);
    pin_in = 0; step(4);
    pin_in = 1; step(1);
    bus_wr = 1; bus_addr = 1; bus_wdata = 16'hABCD; step();
    bus_wr = 0; bus_addr = 1; step(4);
    pin_in = 0;
    run_for(10, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule